// File: doc/BRIEF.md
# Vectored nested interrupt controller

This block gathers 32 level-sensitive interrupt sources and drives a normal interrupt line and a fast interrupt line. Every source can also be raised by software through a set/clear pair of registers. A route register sends each source either to the fast line, which ignores the enable mask, or to the normal line, which honours it.

Sixteen programmable slots bind chosen sources to handler addresses in a fixed priority order, slot 0 being the most urgent. Any other source pending on the normal line is served through a default address. A handler acknowledges by reading the current-vector register. This returns its address and raises the current priority, so equal and lower sources are masked from the normal line. Writing the same register at the end of the handler restores the level that was active before. Handlers can therefore nest up to the depth of the slot table.

Access is through a single-cycle register port with a 12-bit byte offset (word-aligned). Read data appears on `rsp_rdata` one clock after the request. Both interrupt outputs are registered.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset the current level is idle (17), all slot addresses, slot controls and the default address are 0, both interrupt outputs are low, and a current-vector read (byte offset 0x030) with nothing pending returns 0.
- R2: Reading byte offset 0x008 returns raw = src_level OR soft bits. Offset 0x000 returns raw AND enable AND NOT route. Offset 0x004 returns raw AND route. A write to offset 0x000 changes nothing.
- R3: A write to offset 0x010 ORs the data into the enable register and a write to 0x014 clears the bits that are set in the data. Reads of 0x010 return the enable register.
- R4: A write to offset 0x018 ORs the data into the soft bits and a write to 0x01C clears them. Reads of 0x018 return the soft bits, and the soft bits take part in raw exactly like src_level.
- R5: A write to offset 0x00C sets the route register, where 1 selects the fast line. `fiq_out` is high one cycle after raw AND route becomes nonzero, whatever the enable register holds.
- R6: `irq_out` is high one cycle after the normal-line status AND the mask of the current level becomes nonzero. The idle level uses an all-ones mask.
- R7: Slot n has its handler address at byte offset 0x100+4n and its control at 0x200+4n. Control bit 5 enables the slot and bits 4:0 name the source. Both read back. The mask of level k covers the sources of enabled slots below k, and level 16 covers all enabled slots.
- R8: A current-vector read finds the lowest level i below the current one for which raw AND (sources of enabled slots 0..i) is nonzero. It then saves the current level for i, moves to level i and returns slot i's address. With no such i and a non-idle level, it returns the current level's address and the level is unchanged.
- R9: A pending source that no enabled slot names is acknowledged at level 16 and returns the default address, which is written and read at offset 0x034.
- R10: A current-vector read at the idle level with nothing pending returns the default address and leaves the level idle.
- R11: Any write to offset 0x030 while not idle restores the level saved for the current one, so nested handlers unwind in order.
- R12: Reads at offsets 0xFE0+4k, for k = 0..7, return identification byte k in bits 7:0. With the default parameter the bytes are 0x21, 0x43, 0x65, 0x87, 0xA9, 0xCB, 0xED, 0x0F.
- R13: Offset 0x020 holds a protection flag: bit 0 is stored, and the other bits read as 0. Unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read |
| src_level | input | 32 | Hardware interrupt levels |
| irq_out | output | 1 | Normal interrupt line, registered |
| fiq_out | output | 1 | Fast interrupt line, registered |

## Verification
A wrong current level or saved-level entry is visible on `irq_out` one cycle after the acknowledge or end-of-handler access that caused it. It also shows on the address returned by the next current-vector read. The nesting sequence therefore checks the line after every step as well as the returned address. A mask built from the wrong slot, or from a disabled one, makes `irq_out` rise or fail to fall one cycle after a source changes at a non-idle level. A routing fault shows at once on `fiq_out` and in the status reads.

// File: rtl/nic_pkg.sv
package nic_pkg;
  // word indices (byte offset >> 2)
  localparam logic [9:0] W_IRQ_STAT  = 10'd0;
  localparam logic [9:0] W_FIQ_STAT  = 10'd1;
  localparam logic [9:0] W_RAW       = 10'd2;
  localparam logic [9:0] W_ROUTE     = 10'd3;
  localparam logic [9:0] W_EN_SET    = 10'd4;
  localparam logic [9:0] W_EN_CLR    = 10'd5;
  localparam logic [9:0] W_SW_SET    = 10'd6;
  localparam logic [9:0] W_SW_CLR    = 10'd7;
  localparam logic [9:0] W_PROT      = 10'd8;
  localparam logic [9:0] W_VEC       = 10'd12;
  localparam logic [9:0] W_DEFVEC    = 10'd13;
  localparam logic [9:0] W_SLOT_ADDR = 10'h040;
  localparam logic [9:0] W_SLOT_CTL  = 10'h080;
  localparam logic [9:0] W_ID_BASE   = 10'h3F8;

  // slot control byte: bit 5 enable, bits 4:0 source
  typedef struct packed {
    logic       en;
    logic [4:0] src;
  } slot_ctl_t;
endpackage

// File: rtl/nic_slot_bank.sv
module nic_slot_bank
  import nic_pkg::*;
#(
  parameter int NUM_SLOT = 16,
  parameter int DW       = 32,
  localparam int IW      = $clog2(NUM_SLOT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_we,
  input  logic              ctl_we,
  input  logic [IW-1:0]     idx,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     slot_addr [NUM_SLOT],
  output slot_ctl_t         slot_ctl  [NUM_SLOT]
);
  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_addr[g] <= '0;
        slot_ctl[g]  <= '0;
      end else begin
        if (addr_we && idx == IW'(g)) slot_addr[g] <= wdata;
        if (ctl_we && idx == IW'(g))  slot_ctl[g]  <= wdata[5:0];
      end
    end
  end
endmodule

// File: rtl/nic_mask_gen.sv
module nic_mask_gen
  import nic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  localparam int NLVL    = NUM_SLOT + 2
) (
  input  slot_ctl_t          slot_ctl [NUM_SLOT],
  output logic [NUM_SRC-1:0] lvl_mask [NLVL]
);
  logic [NUM_SRC-1:0] slot_bit [NUM_SLOT];

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_bit
    assign slot_bit[g] = slot_ctl[g].en ? (NUM_SRC'(1) << slot_ctl[g].src) : '0;
  end

  // level k masks sources of enabled slots strictly above it in priority
  always_comb begin
    for (int k = 0; k < NLVL - 1; k++) begin
      lvl_mask[k] = '0;
      for (int j = 0; j < NUM_SLOT; j++) begin
        if (j < k) lvl_mask[k] = lvl_mask[k] | slot_bit[j];
      end
    end
    lvl_mask[NLVL-1] = '1;
  end
endmodule

// File: rtl/nic_prio_stack.sv
module nic_prio_stack #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  localparam int NLVL    = NUM_SLOT + 2,
  localparam int LW      = $clog2(NLVL),
  localparam logic [LW-1:0] IDLE = LW'(NUM_SLOT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] raw,
  input  logic [NUM_SRC-1:0] lvl_mask [NLVL],
  input  logic               ack,
  input  logic               eoi,
  output logic [LW-1:0]      cur_prio,
  output logic [LW-1:0]      grant_lvl,
  output logic               grant_hit
);
  logic [LW-1:0] saved [NUM_SLOT+1];

  // lowest level below the current one with something pending
  always_comb begin
    grant_lvl = cur_prio;
    for (int i = NUM_SLOT; i >= 0; i--) begin
      if (LW'(i) < cur_prio && |(raw & lvl_mask[i+1])) grant_lvl = LW'(i);
    end
    grant_hit = grant_lvl < cur_prio;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_prio <= IDLE;
      for (int i = 0; i <= NUM_SLOT; i++) saved[i] <= IDLE;
    end else if (ack && grant_hit) begin
      saved[grant_lvl] <= cur_prio;
      cur_prio         <= grant_lvl;
    end else if (eoi && cur_prio != IDLE) begin
      cur_prio <= saved[cur_prio];
    end
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int          NUM_SRC  = 32,
  parameter int          NUM_SLOT = 16,
  parameter logic [63:0] ID_BYTES = 64'h0FED_CBA9_8765_4321
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [11:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic [31:0] rsp_rdata,
  input  logic [31:0] src_level,
  output logic        irq_out,
  output logic        fiq_out
);
  localparam int DW   = 32;
  localparam int NLVL = NUM_SLOT + 2;
  localparam int LW   = $clog2(NLVL);
  localparam int IW   = $clog2(NUM_SLOT);

  logic [9:0] word;
  logic       unused_lsb;
  assign word       = req_addr[11:2];
  assign unused_lsb = ^req_addr[1:0];

  logic wr, rd;
  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  logic in_addr, in_ctl;
  assign in_addr = word >= W_SLOT_ADDR && word < W_SLOT_ADDR + 10'(NUM_SLOT);
  assign in_ctl  = word >= W_SLOT_CTL  && word < W_SLOT_CTL  + 10'(NUM_SLOT);

  logic [NUM_SRC-1:0] en_q, sel_q, soft_q;
  logic               prot_q;
  logic [DW-1:0]      def_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      sel_q  <= '0;
      soft_q <= '0;
      prot_q <= 1'b0;
      def_q  <= '0;
    end else if (wr) begin
      case (word)
        W_ROUTE:  sel_q  <= req_wdata[NUM_SRC-1:0];
        W_EN_SET: en_q   <= en_q | req_wdata[NUM_SRC-1:0];
        W_EN_CLR: en_q   <= en_q & ~req_wdata[NUM_SRC-1:0];
        W_SW_SET: soft_q <= soft_q | req_wdata[NUM_SRC-1:0];
        W_SW_CLR: soft_q <= soft_q & ~req_wdata[NUM_SRC-1:0];
        W_PROT:   prot_q <= req_wdata[0];
        W_DEFVEC: def_q  <= req_wdata;
        default: ;
      endcase
    end
  end

  logic [DW-1:0]      slot_addr [NUM_SLOT];
  slot_ctl_t          slot_ctl  [NUM_SLOT];
  logic [NUM_SRC-1:0] lvl_mask  [NLVL];

  nic_slot_bank #(.NUM_SLOT(NUM_SLOT), .DW(DW)) u_slots (
    .clk(clk), .rst(rst),
    .addr_we(wr && in_addr), .ctl_we(wr && in_ctl),
    .idx(word[IW-1:0]), .wdata(req_wdata),
    .slot_addr(slot_addr), .slot_ctl(slot_ctl)
  );

  nic_mask_gen #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) u_mask (
    .slot_ctl(slot_ctl), .lvl_mask(lvl_mask)
  );

  logic [NUM_SRC-1:0] raw, irq_stat, fiq_stat;
  assign raw      = src_level[NUM_SRC-1:0] | soft_q;
  assign irq_stat = raw & en_q & ~sel_q;
  assign fiq_stat = raw & sel_q;

  logic [LW-1:0] cur_prio, grant_lvl;
  logic          grant_hit;

  nic_prio_stack #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) u_stack (
    .clk(clk), .rst(rst), .raw(raw), .lvl_mask(lvl_mask),
    .ack(rd && word == W_VEC), .eoi(wr && word == W_VEC),
    .cur_prio(cur_prio), .grant_lvl(grant_lvl), .grant_hit(grant_hit)
  );

  // slot addresses extended with the default at level 16 and idle
  logic [DW-1:0] vec_tab [NLVL];
  always_comb begin
    for (int i = 0; i < NUM_SLOT; i++) vec_tab[i] = slot_addr[i];
    vec_tab[NLVL-2] = def_q;
    vec_tab[NLVL-1] = def_q;
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (in_addr) begin
      rd_mux = slot_addr[word[IW-1:0]];
    end else if (in_ctl) begin
      rd_mux = DW'(slot_ctl[word[IW-1:0]]);
    end else if (word >= W_ID_BASE) begin
      rd_mux = DW'(ID_BYTES[{word[2:0], 3'b000} +: 8]);
    end else begin
      case (word)
        W_IRQ_STAT: rd_mux = DW'(irq_stat);
        W_FIQ_STAT: rd_mux = DW'(fiq_stat);
        W_RAW:      rd_mux = DW'(raw);
        W_ROUTE:    rd_mux = DW'(sel_q);
        W_EN_SET:   rd_mux = DW'(en_q);
        W_SW_SET:   rd_mux = DW'(soft_q);
        W_PROT:     rd_mux = DW'(prot_q);
        W_VEC:      rd_mux = vec_tab[grant_lvl];
        W_DEFVEC:   rd_mux = def_q;
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata <= '0;
      irq_out   <= 1'b0;
      fiq_out   <= 1'b0;
    end else begin
      if (rd) rsp_rdata <= rd_mux;
      irq_out <= |(irq_stat & lvl_mask[cur_prio]);
      fiq_out <= |fiq_stat;
    end
  end
endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  localparam int LW      = $clog2(NUM_SLOT + 2),
  localparam logic [LW-1:0] IDLE = LW'(NUM_SLOT + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_write,
  input logic [11:0]        req_addr,
  input logic [LW-1:0]      cur_prio,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] sel_q,
  input logic               irq_out,
  input logic               fiq_out
);
  logic vec_acc;
  assign vec_acc = req_valid && req_addr[11:2] == 10'd12;

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> cur_prio == IDLE && !irq_out && !fiq_out);

  p_prio_range_r8: assert property (@(posedge clk) disable iff (rst) cur_prio <= IDLE);

  p_ack_lowers_r8: assert property (@(posedge clk) disable iff (rst)
    (vec_acc && !req_write) |=> cur_prio <= $past(cur_prio));

  p_eoi_raises_r11: assert property (@(posedge clk) disable iff (rst)
    (vec_acc && req_write && cur_prio != IDLE) |=> cur_prio > $past(cur_prio));

  p_fiq_needs_route_r5: assert property (@(posedge clk) disable iff (rst)
    (sel_q == '0) |=> !fiq_out);

  p_irq_needs_enable_r6: assert property (@(posedge clk) disable iff (rst)
    ((en_q & ~sel_q) == '0) |=> !irq_out);
endmodule

bind nest_irq_ctrl nic_checker #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .cur_prio(cur_prio), .en_q(en_q), .sel_q(sel_q),
  .irq_out(irq_out), .fiq_out(fiq_out)
);

// File: tb/nest_irq_ctrl_test.sv
`timescale 1ns/1ps
module nest_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [11:0] req_addr;
  logic [31:0] req_wdata, rsp_rdata, src_level;
  logic        irq_out, fiq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  nest_irq_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .src_level(src_level), .irq_out(irq_out), .fiq_out(fiq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic clean();
    src_level = '0;
    wr(12'h014, 32'hFFFF_FFFF);
    wr(12'h01C, 32'hFFFF_FFFF);
    wr(12'h00C, 32'h0);
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 irq_out after reset", 32'(irq_out), 32'h0);
    check("R1 fiq_out after reset", 32'(fiq_out), 32'h0);
    rd(12'h100, v); check("R1 slot0 addr reset", v, 32'h0);
    rd(12'h23C, v); check("R1 slot15 ctl reset", v, 32'h0);
    rd(12'h034, v); check("R1 default addr reset", v, 32'h0);
    rd(12'h030, v); check("R1 vector read idle", v, 32'h0);
  endtask

  task automatic t_status();
    logic [31:0] v;
    src_level = 32'h0000_00F0;
    wr(12'h018, 32'h0F00_0000);
    wr(12'h010, 32'h0000_00FF);
    wr(12'h00C, 32'h0000_00C0);
    rd(12'h008, v); check("R2 raw", v, 32'h0F00_00F0);
    rd(12'h000, v); check("R2 irq status", v, 32'h0000_0030);
    rd(12'h004, v); check("R2 fiq status", v, 32'h0000_00C0);
    rd(12'h00C, v); check("R5 route readback", v, 32'h0000_00C0);
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, v); check("R2 irq status write ignored", v, 32'h0000_0030);
    wr(12'h010, 32'h0000_0F00);
    wr(12'h014, 32'h0000_000F);
    rd(12'h010, v); check("R3 enable set/clear", v, 32'h0000_0FF0);
    wr(12'h01C, 32'h0300_0000);
    rd(12'h018, v); check("R4 soft clear", v, 32'h0C00_0000);
    rd(12'h008, v); check("R4 soft in raw", v, 32'h0C00_00F0);
    clean();
  endtask

  task automatic t_fiq();
    src_level = 32'h0000_0020;
    wr(12'h00C, 32'h0000_0020);
    settle();
    check("R5 fiq without enable", 32'(fiq_out), 32'h1);
    check("R6 irq low when routed fast", 32'(irq_out), 32'h0);
    wr(12'h00C, 32'h0);
    settle();
    check("R5 fiq drops", 32'(fiq_out), 32'h0);
    check("R6 irq needs enable", 32'(irq_out), 32'h0);
    wr(12'h010, 32'h0000_0020);
    settle();
    check("R6 irq at idle level", 32'(irq_out), 32'h1);
    clean();
  endtask

  task automatic t_id_misc();
    logic [31:0] v;
    logic [7:0] id [8] = '{8'h21, 8'h43, 8'h65, 8'h87, 8'hA9, 8'hCB, 8'hED, 8'h0F};
    for (int k = 0; k < 8; k++) begin
      rd(12'hFE0 + 12'(4 * k), v);
      check("R12 id byte", v, 32'(id[k]));
    end
    wr(12'h020, 32'hFFFF_FFFF);
    rd(12'h020, v); check("R13 protection bit", v, 32'h1);
    wr(12'h024, 32'hFFFF_FFFF);
    rd(12'h024, v); check("R13 unmapped reads zero", v, 32'h0);
    rd(12'h500, v); check("R13 unmapped region", v, 32'h0);
  endtask

  task automatic t_nested();
    logic [31:0] v;
    wr(12'h034, 32'h0000_3000);
    wr(12'h100, 32'h0000_1000);
    wr(12'h104, 32'h0000_2000);
    wr(12'h200, 32'h0000_0023);
    wr(12'h204, 32'h0000_0027);
    wr(12'h208, 32'h0000_0009);
    rd(12'h204, v); check("R7 ctl readback", v, 32'h0000_0027);
    rd(12'h104, v); check("R7 addr readback", v, 32'h0000_2000);
    rd(12'h034, v); check("R9 default readback", v, 32'h0000_3000);
    wr(12'h010, 32'h0000_0288);
    src_level = 32'h0000_0080;
    settle();
    check("R6 irq idle src7", 32'(irq_out), 32'h1);
    rd(12'h030, v); check("R8 ack slot1", v, 32'h0000_2000);
    settle();
    check("R8 level1 masks src7", 32'(irq_out), 32'h0);
    src_level = 32'h0000_0088;
    settle();
    check("R7 slot0 preempts", 32'(irq_out), 32'h1);
    rd(12'h030, v); check("R8 ack slot0", v, 32'h0000_1000);
    settle();
    check("R8 level0 masks all", 32'(irq_out), 32'h0);
    src_level = 32'h0000_0288;
    settle();
    check("R7 disabled slot not vectored", 32'(irq_out), 32'h0);
    rd(12'h030, v); check("R8 re-read at level0", v, 32'h0000_1000);
    wr(12'h030, 32'h0);
    settle();
    check("R11 back to level1", 32'(irq_out), 32'h1);
    src_level = 32'h0000_0280;
    settle();
    check("R11 level1 mask", 32'(irq_out), 32'h0);
    wr(12'h030, 32'h0);
    settle();
    check("R11 back to idle", 32'(irq_out), 32'h1);
    src_level = 32'h0000_0200;
    rd(12'h030, v); check("R9 unvectored gets default", v, 32'h0000_3000);
    settle();
    check("R9 level16 masks unvectored", 32'(irq_out), 32'h0);
    src_level = 32'h0000_0080;
    settle();
    check("R9 level16 passes slot source", 32'(irq_out), 32'h1);
    wr(12'h030, 32'h0);
    src_level = 32'h0;
    rd(12'h030, v); check("R10 idle nothing pending", v, 32'h0000_3000);
    src_level = 32'h0000_0200;
    settle();
    check("R10 level stays idle", 32'(irq_out), 32'h1);
    clean();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; src_level = '0;
    t_reset();
    t_status();
    t_fiq();
    t_id_misc();
    t_nested();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule